// File: doc/BRIEF.md
# Zone Password and Attempts Controller

This block decides, for one addressed user zone out of eight, whether a read is allowed, whether a write is allowed, and which stored bits a write may change. Every zone has an 8-bit access register whose option bits are active low. The register names the password set that guards the zone and can turn on a write-password requirement, a read-password requirement, an authentication requirement, a no-write mode and a clear-only mode. Eight sets hold one write password and one read password each, all 24 bits wide.

Each of the sixteen passwords has an 8-bit attempts counter. A counter loses one more bit on every wrong presentation and returns to all ones on a correct one. Only one password identity is active at any time. An authentication-valid flag is set and cleared by strobes from an external authentication engine and by a session reset. A configuration port loads the access registers and the passwords. The attempts counter picked by a query selector can be read back at any time.

The permission outputs are combinational from the zone index, that zone's access register, the active identity, the authentication flag and the personalization fuse. A verify request changes the state on the next clock edge.

Top module: `zone_acl_ctrl`

## Requirements
- R1: The access register fields are: bit 7 write-password requirement, bit 6 read-password requirement, bit 5 authentication requirement, bits 4:2 password set, bit 1 no-write mode, bit 0 clear-only mode. Each option is on when its bit is 0. A zone whose register is 8'hFF can be read and written freely.
- R2: The verify selector `vfySel` is 4 bits wide. Bit 3 is 0 for the write password and 1 for the read password, and bits 2:0 give the set. The same encoding indexes the attempts counters through `cntQuerySel`.
- R3: A wrong presentation shifts the selected counter left by one, so 8'hFF becomes 8'hFE and then 8'hFC. A correct presentation restores 8'hFF. The state is updated on the clock edge that samples `vfyReq`.
- R4: When the selected counter is 8'h00, a verify request is ignored. The counter stays at 0 and the active identity is unchanged, even if the password matches.
- R5: Any verify request that is taken, wrong or right, replaces the active identity. A wrong one leaves no identity active. `cardRst` also clears the active identity.
- R6: An active write password grants both read and write to every zone that names its set. An active read password grants read to every zone that names its set.
- R7: In clear-only mode an allowed write commits old AND new, and `wrMask` equals the old byte. In no-write mode `wrOk` is 0.
- R8: While `persFuse` is 1, every zone requires its write password regardless of register bit 7.
- R9: The authentication flag is cleared by `cardRst`, by `authInit`, and by `authDone` with `authPass`=0. It is set by `authDone` with `authPass`=1. A zone with the authentication requirement on grants nothing while the flag is 0.
- R10: After `rstN`, every access register is 8'hFF, every counter is 8'hFF, every password is 0, no identity is active and the authentication flag is 0.
- R11: When `wrOk` is 0, `wrData` equals `curData` and `wrMask` is 0. When a write is allowed outside clear-only mode, `wrData` equals `newData` and `wrMask` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| cardRst | input | 1 | Session reset; drops the active identity and the authentication flag |
| persFuse | input | 1 | Personalization fuse, 1 while personalization is still open |
| cfgWe | input | 1 | Configuration write strobe |
| cfgKind | input | 2 | 0 access register, 1 write password, 2 read password |
| cfgIdx | input | 3 | Zone or set index of the configuration write |
| cfgData | input | 24 | Password value; bits 7:0 carry an access register value |
| vfyReq | input | 1 | Verify request strobe |
| vfySel | input | 4 | Password selector of the request |
| vfyPw | input | 24 | Presented password |
| authInit | input | 1 | A new authentication has started |
| authDone | input | 1 | The authentication result is valid |
| authPass | input | 1 | The authentication result: 1 means success |
| cntQuerySel | input | 4 | Selects the attempts counter shown on cntValue |
| cntValue | output | 8 | The selected attempts counter |
| zone | input | 3 | Addressed user zone |
| curData | input | 8 | Byte currently stored at the address |
| newData | input | 8 | Byte the host wants to write |
| rdOk | output | 1 | A read of the zone is allowed |
| wrOk | output | 1 | A write to the zone is allowed |
| wrData | output | 8 | Byte to commit |
| wrMask | output | 8 | Bits the write may change |

## Verification
The hardest state to reach is a locked counter that meets a correct password while another identity is active. Reaching it takes eight wrong presentations to one selector, then a correct presentation of a different password, and only then the matching password for the locked selector. The stimulus builds this sequence step by step and checks the counter after the seventh and the eighth failure. It then confirms that the earlier write rights survive. The authentication flag sequence is driven the same way, alternating pass, init, fail and session reset while a zone with the authentication requirement is addressed.

// File: rtl/zone_acl_pkg.sv
package zone_acl_pkg;
  localparam int NUM_SETS = 8;
  localparam int SET_W    = $clog2(NUM_SETS);
  localparam int SEL_W    = SET_W + 1;
  localparam int NUM_PW   = 2 * NUM_SETS;
  localparam int AR_W     = 8;

  typedef enum logic [1:0] {
    CFG_ACCESS = 2'd0,
    CFG_WRPW   = 2'd1,
    CFG_RDPW   = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_kind_e;

  // control -> datapath counter strobes
  typedef struct packed {
    logic             cntRestore;
    logic             cntFail;
    logic [SEL_W-1:0] cntIdx;
  } cnt_strobe_t;
endpackage

// File: rtl/zone_acl_ctl.sv
module zone_acl_ctl
  import zone_acl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cardRst,
  input  logic             vfyReq,
  input  logic [SEL_W-1:0] vfySel,
  input  logic             selMatch,
  input  logic             selLocked,
  input  logic             authInit,
  input  logic             authDone,
  input  logic             authPass,
  output cnt_strobe_t      strobe,
  output logic             activeValid,
  output logic [SEL_W-1:0] activeSel,
  output logic             authFlag
);
  logic take;

  // a request on a locked counter is dropped entirely
  assign take = vfyReq && !selLocked;

  always_comb begin
    strobe.cntRestore = take && selMatch;
    strobe.cntFail    = take && !selMatch;
    strobe.cntIdx     = vfySel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeValid <= 1'b0;
      activeSel   <= '0;
    end else if (cardRst) begin
      activeValid <= 1'b0;
    end else if (take) begin
      activeValid <= selMatch;
      activeSel   <= vfySel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         authFlag <= 1'b0;
    else if (cardRst)  authFlag <= 1'b0;
    else if (authInit) authFlag <= 1'b0;
    else if (authDone) authFlag <= authPass;
  end
endmodule

// File: rtl/zone_acl_dp.sv
module zone_acl_dp
  import zone_acl_pkg::*;
#(
  parameter int PW_W   = 24,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              persFuse,
  input  logic              cfgWe,
  input  logic [1:0]        cfgKind,
  input  logic [SET_W-1:0]  cfgIdx,
  input  logic [PW_W-1:0]   cfgData,
  input  cnt_strobe_t       strobe,
  input  logic [SEL_W-1:0]  vfySel,
  input  logic [PW_W-1:0]   vfyPw,
  input  logic [SEL_W-1:0]  cntQuerySel,
  input  logic [SET_W-1:0]  zone,
  input  logic [DATA_W-1:0] curData,
  input  logic [DATA_W-1:0] newData,
  input  logic              activeValid,
  input  logic [SEL_W-1:0]  activeSel,
  input  logic              authFlag,
  output logic              selMatch,
  output logic              selLocked,
  output logic [CNT_W-1:0]  cntValue,
  output logic [AR_W-1:0]   arCur,
  output logic              rdOk,
  output logic              wrOk,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] wrMask
);
  logic [AR_W-1:0]  accReg [NUM_SETS];
  logic [PW_W-1:0]  pwWr   [NUM_SETS];
  logic [PW_W-1:0]  pwRd   [NUM_SETS];
  logic [CNT_W-1:0] cnt    [NUM_PW];
  logic [NUM_PW-1:0] pwHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SETS; i++) begin
        accReg[i] <= '1;
        pwWr[i]   <= '0;
        pwRd[i]   <= '0;
      end
    end else if (cfgWe) begin
      case (cfg_kind_e'(cfgKind))
        CFG_ACCESS: accReg[cfgIdx] <= cfgData[AR_W-1:0];
        CFG_WRPW:   pwWr[cfgIdx]   <= cfgData;
        CFG_RDPW:   pwRd[cfgIdx]   <= cfgData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PW; i++) cnt[i] <= '1;
    end else begin
      for (int i = 0; i < NUM_PW; i++) begin
        if (strobe.cntIdx == SEL_W'(i)) begin
          if (strobe.cntRestore)   cnt[i] <= '1;
          else if (strobe.cntFail) cnt[i] <= cnt[i] << 1;
        end
      end
    end
  end

  // selector index: lower half write passwords, upper half read passwords
  for (genvar g = 0; g < NUM_PW; g++) begin : g_cmp
    if (g < NUM_SETS) begin : g_wr
      assign pwHit[g] = (pwWr[g] == vfyPw);
    end else begin : g_rd
      assign pwHit[g] = (pwRd[g-NUM_SETS] == vfyPw);
    end
  end

  assign selMatch  = pwHit[vfySel];
  assign selLocked = (cnt[vfySel] == '0);
  assign cntValue  = cnt[cntQuerySel];
  assign arCur     = accReg[zone];

  logic             needWr, needRd, needAuth, noWrite, clearOnly;
  logic [SET_W-1:0] zoneSet;
  logic             haveWr, haveRd, authOk;

  always_comb begin
    needWr    = !arCur[7] || persFuse;
    needRd    = !arCur[6];
    needAuth  = !arCur[5];
    zoneSet   = arCur[4:2];
    noWrite   = !arCur[1];
    clearOnly = !arCur[0];
    haveWr    = activeValid && !activeSel[SEL_W-1] && (activeSel[SET_W-1:0] == zoneSet);
    haveRd    = activeValid &&  activeSel[SEL_W-1] && (activeSel[SET_W-1:0] == zoneSet);
    authOk    = !needAuth || authFlag;
    rdOk      = authOk && (!needRd || haveWr || haveRd);
    wrOk      = authOk && !noWrite && (!needWr || haveWr);
    if (!wrOk)          wrMask = '0;
    else if (clearOnly) wrMask = curData;
    else                wrMask = '1;
    wrData = (newData & wrMask) | (curData & ~wrMask);
  end
endmodule

// File: rtl/zone_acl_ctrl.sv
module zone_acl_ctrl
  import zone_acl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cardRst,
  input  logic        persFuse,
  input  logic        cfgWe,
  input  logic [1:0]  cfgKind,
  input  logic [2:0]  cfgIdx,
  input  logic [23:0] cfgData,
  input  logic        vfyReq,
  input  logic [3:0]  vfySel,
  input  logic [23:0] vfyPw,
  input  logic        authInit,
  input  logic        authDone,
  input  logic        authPass,
  input  logic [3:0]  cntQuerySel,
  output logic [7:0]  cntValue,
  input  logic [2:0]  zone,
  input  logic [7:0]  curData,
  input  logic [7:0]  newData,
  output logic        rdOk,
  output logic        wrOk,
  output logic [7:0]  wrData,
  output logic [7:0]  wrMask
);
  cnt_strobe_t      strobe;
  logic             selMatch, selLocked, activeValid, authFlag;
  logic [SEL_W-1:0] activeSel;
  logic [AR_W-1:0]  arCur;

  zone_acl_ctl ctl_i (
    .clk(clk), .rstN(rstN), .cardRst(cardRst), .vfyReq(vfyReq), .vfySel(vfySel),
    .selMatch(selMatch), .selLocked(selLocked), .authInit(authInit),
    .authDone(authDone), .authPass(authPass), .strobe(strobe),
    .activeValid(activeValid), .activeSel(activeSel), .authFlag(authFlag)
  );

  zone_acl_dp #(.PW_W(24), .CNT_W(8), .DATA_W(8)) dp_i (
    .clk(clk), .rstN(rstN), .persFuse(persFuse), .cfgWe(cfgWe), .cfgKind(cfgKind),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .strobe(strobe), .vfySel(vfySel),
    .vfyPw(vfyPw), .cntQuerySel(cntQuerySel), .zone(zone), .curData(curData),
    .newData(newData), .activeValid(activeValid), .activeSel(activeSel),
    .authFlag(authFlag), .selMatch(selMatch), .selLocked(selLocked),
    .cntValue(cntValue), .arCur(arCur), .rdOk(rdOk), .wrOk(wrOk),
    .wrData(wrData), .wrMask(wrMask)
  );
endmodule

// File: rtl/zone_acl_chk.sv
module zone_acl_chk
  import zone_acl_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cardRst,
  input logic             persFuse,
  input logic             vfyReq,
  input logic             authInit,
  input logic             authDone,
  input logic             authPass,
  input logic [7:0]       curData,
  input logic             rdOk,
  input logic             wrOk,
  input logic [7:0]       wrData,
  input logic [7:0]       wrMask,
  input cnt_strobe_t      strobe,
  input logic             selLocked,
  input logic             activeValid,
  input logic [SEL_W-1:0] activeSel,
  input logic             authFlag,
  input logic [AR_W-1:0]  arCur
);
  p_nowrite_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    !arCur[1] |-> !wrOk);

  p_clear_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && !arCur[0]) |-> ((wrData & ~curData) == 8'h00));

  p_deny_keeps_r11: assert property (@(posedge clk) disable iff (!rstN)
    !wrOk |-> (wrData == curData && wrMask == 8'h00));

  p_pers_forces_r8: assert property (@(posedge clk) disable iff (!rstN)
    (persFuse && wrOk) |-> (activeValid && !activeSel[SEL_W-1] &&
                            activeSel[SET_W-1:0] == arCur[4:2]));

  p_locked_no_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    (vfyReq && selLocked) |-> !(strobe.cntRestore || strobe.cntFail));

  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (vfyReq && selLocked && !cardRst) |=> ($stable(activeValid) && $stable(activeSel)));

  p_fail_revokes_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntFail |=> !activeValid);

  p_auth_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cardRst || authInit || (authDone && !authPass)) |=> !authFlag);

  p_auth_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!arCur[5] && !authFlag) |-> (!rdOk && !wrOk));
endmodule

bind zone_acl_ctrl zone_acl_chk chk_i (
  .clk(clk), .rstN(rstN), .cardRst(cardRst), .persFuse(persFuse), .vfyReq(vfyReq),
  .authInit(authInit), .authDone(authDone), .authPass(authPass), .curData(curData),
  .rdOk(rdOk), .wrOk(wrOk), .wrData(wrData), .wrMask(wrMask), .strobe(strobe),
  .selLocked(selLocked), .activeValid(activeValid), .activeSel(activeSel),
  .authFlag(authFlag), .arCur(arCur)
);

// File: tb/zone_acl_ctrl_tb.sv
module zone_acl_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cardRst = 1'b0, persFuse = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgKind = 2'd3;
  logic [2:0]  cfgIdx = 3'd0;
  logic [23:0] cfgData = 24'd0;
  logic        vfyReq = 1'b0;
  logic [3:0]  vfySel = 4'd0;
  logic [23:0] vfyPw = 24'd0;
  logic        authInit = 1'b0, authDone = 1'b0, authPass = 1'b0;
  logic [3:0]  cntQuerySel = 4'd0;
  logic [7:0]  cntValue;
  logic [2:0]  zone = 3'd5;
  logic [7:0]  curData = 8'h5A, newData = 8'hA5;
  logic        rdOk, wrOk;
  logic [7:0]  wrData, wrMask;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zone_acl_ctrl dut_i (.*);

  // reference model state
  logic [7:0]  mAr  [8];
  logic [23:0] mWp  [8];
  logic [23:0] mRp  [8];
  logic [7:0]  mCnt [16];
  bit          mActV, mAuth;
  logic [3:0]  mActSel;

  function automatic logic [23:0] wpOf(int s); return 24'hA00000 + 24'(s) * 24'h111; endfunction
  function automatic logic [23:0] rpOf(int s); return 24'h5B0000 + 24'(s) * 24'h0F0; endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin mAr[i] = 8'hFF; mWp[i] = 0; mRp[i] = 0; end
      for (int i = 0; i < 16; i++) mCnt[i] = 8'hFF;
      mActV = 0; mActSel = 0; mAuth = 0;
    end else begin
      int idx;
      logic [23:0] stored;
      idx = vfySel;
      stored = vfySel[3] ? mRp[vfySel[2:0]] : mWp[vfySel[2:0]];
      if (vfyReq && mCnt[idx] != 8'h00) begin
        if (stored == vfyPw) begin
          mCnt[idx] = 8'hFF;
          if (!cardRst) begin mActV = 1; mActSel = vfySel; end
        end else begin
          mCnt[idx] = mCnt[idx] & (mCnt[idx] - 8'd1);
          if (!cardRst) mActV = 0;
        end
      end
      if (cardRst) begin mActV = 0; mAuth = 0; end
      else if (authInit) mAuth = 0;
      else if (authDone) mAuth = authPass;
      if (cfgWe) begin
        if (cfgKind == 2'd0) mAr[cfgIdx] = cfgData[7:0];
        else if (cfgKind == 2'd1) mWp[cfgIdx] = cfgData;
        else if (cfgKind == 2'd2) mRp[cfgIdx] = cfgData;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [7:0] ar, eD, eM;
      bit wNeed, hasW, hasR, aGood, eR, eW;
      ar    = mAr[zone];
      wNeed = (ar[7] == 1'b0) || persFuse;
      hasW  = mActV && (mActSel == {1'b0, ar[4:2]});
      hasR  = mActV && (mActSel == {1'b1, ar[4:2]});
      aGood = ar[5] || mAuth;
      eR    = aGood && (ar[6] || hasW || hasR);
      eW    = aGood && ar[1] && (!wNeed || hasW);
      if (!eW) begin eD = curData; eM = 8'h00; end
      else if (!ar[0]) begin eD = curData & newData; eM = curData; end
      else begin eD = newData; eM = 8'hFF; end
      chk("R6 model rdOk", 32'(rdOk), 32'(eR));
      chk("R1 model wrOk", 32'(wrOk), 32'(eW));
      chk("R7 model wrData", 32'(wrData), 32'(eD));
      chk("R11 model wrMask", 32'(wrMask), 32'(eM));
      chk("R3 model cntValue", 32'(cntValue), 32'(mCnt[cntQuerySel]));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic verify(input logic [3:0] sel, input logic [23:0] pw);
    vfyReq = 1; vfySel = sel; vfyPw = pw; tick(); vfyReq = 0;
  endtask

  task automatic cfg(input logic [1:0] kind, input int idx, input logic [23:0] data);
    cfgWe = 1; cfgKind = kind; cfgIdx = 3'(idx); cfgData = data; tick(); cfgWe = 0;
  endtask

  task automatic look(input logic [2:0] z, input logic [7:0] c, input logic [7:0] n);
    zone = z; curData = c; newData = n; @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    look(3'd5, 8'h5A, 8'hA5);
    chk("R10 rdOk after reset", 32'(rdOk), 1);
    chk("R10 wrOk after reset", 32'(wrOk), 1);
    chk("R10 wrData free write", 32'(wrData), 32'hA5);
    chk("R10 counter after reset", 32'(cntValue), 32'hFF);

    persFuse = 1;
    look(3'd5, 8'h5A, 8'hA5);
    chk("R8 fuse forces write password", 32'(wrOk), 0);
    verify(4'b0111, 24'h0);
    look(3'd5, 8'h5A, 8'hA5);
    chk("R8 write password 7 opens zone", 32'(wrOk), 1);
    persFuse = 0;

    for (int s = 0; s < 8; s++) begin
      cfg(2'd1, s, wpOf(s));
      cfg(2'd2, s, rpOf(s));
    end
    cfg(2'd0, 0, 24'h23);
    cfg(2'd0, 1, 24'h23);
    cfg(2'd0, 2, 24'h66);
    cfg(2'd0, 3, 24'hE9);
    cfg(2'd0, 4, 24'hCF);

    look(3'd0, 8'h11, 8'h22);
    chk("R1 zone0 read needs password", 32'(rdOk), 0);
    chk("R1 zone0 write needs password", 32'(wrOk), 0);

    verify(4'b1000, rpOf(0));
    look(3'd0, 8'h11, 8'h22);
    chk("R2 read password opens read", 32'(rdOk), 1);
    chk("R2 read password no write", 32'(wrOk), 0);
    look(3'd1, 8'h11, 8'h22);
    chk("R6 shared set zone1 read", 32'(rdOk), 1);

    verify(4'b0000, wpOf(0));
    look(3'd1, 8'h11, 8'h22);
    chk("R6 write password zone1 write", 32'(wrOk), 1);
    chk("R6 write password zone1 read", 32'(rdOk), 1);

    cntQuerySel = 4'd0;
    verify(4'b0000, 24'h123456);
    look(3'd0, 8'h11, 8'h22);
    chk("R5 failed attempt revokes read", 32'(rdOk), 0);
    chk("R3 one bit cleared", 32'(cntValue), 32'hFE);
    verify(4'b0000, 24'h123456);
    look(3'd0, 8'h11, 8'h22);
    chk("R3 two bits cleared", 32'(cntValue), 32'hFC);
    verify(4'b0000, wpOf(0));
    look(3'd0, 8'h11, 8'h22);
    chk("R3 correct restores", 32'(cntValue), 32'hFF);

    cntQuerySel = 4'd9;
    for (int k = 0; k < 7; k++) verify(4'b1001, 24'h0BAD00);
    look(3'd0, 8'h11, 8'h22);
    chk("R3 seven failures", 32'(cntValue), 32'h80);
    verify(4'b1001, 24'h0BAD00);
    look(3'd0, 8'h11, 8'h22);
    chk("R3 eight failures", 32'(cntValue), 32'h00);

    verify(4'b0000, wpOf(0));
    verify(4'b1001, rpOf(1));
    look(3'd0, 8'h11, 8'h22);
    chk("R4 locked request keeps identity", 32'(wrOk), 1);
    chk("R4 locked counter stays zero", 32'(cntValue), 32'h00);

    verify(4'b0001, wpOf(1));
    look(3'd2, 8'hF0, 8'h3C);
    chk("R7 clear-only allowed", 32'(wrOk), 1);
    chk("R7 clear-only data", 32'(wrData), 32'h30);
    chk("R7 clear-only mask", 32'(wrMask), 32'hF0);
    look(3'd3, 8'h77, 8'h00);
    chk("R7 no-write blocks", 32'(wrOk), 0);
    chk("R11 denied keeps data", 32'(wrData), 32'h77);
    chk("R11 denied mask", 32'(wrMask), 32'h00);

    look(3'd4, 8'h01, 8'h02);
    chk("R9 no auth no read", 32'(rdOk), 0);
    authDone = 1; authPass = 1; tick(); authDone = 0;
    look(3'd4, 8'h01, 8'h02);
    chk("R9 auth pass read", 32'(rdOk), 1);
    chk("R9 auth pass write", 32'(wrOk), 1);
    authInit = 1; tick(); authInit = 0;
    look(3'd4, 8'h01, 8'h02);
    chk("R9 init drops auth", 32'(rdOk), 0);
    authDone = 1; authPass = 1; tick(); authPass = 0; tick(); authDone = 0;
    look(3'd4, 8'h01, 8'h02);
    chk("R9 failed result drops auth", 32'(rdOk), 0);
    authDone = 1; authPass = 1; tick(); authDone = 0; authPass = 0;
    cardRst = 1; tick(); cardRst = 0;
    look(3'd4, 8'h01, 8'h02);
    chk("R9 session reset drops auth", 32'(rdOk), 0);
    look(3'd2, 8'hF0, 8'h3C);
    chk("R5 session reset drops identity", 32'(wrOk), 0);

    persFuse = 1;
    look(3'd5, 8'h5A, 8'hA5);
    chk("R8 fuse on free zone", 32'(wrOk), 0);
    chk("R1 free zone read under fuse", 32'(rdOk), 1);
    persFuse = 0;
    tick();
    finishRun();
  end
endmodule